// File: doc/BRIEF.md
# Paged Nonvolatile Write Engine

This block is a cycle-accurate model of the write path of a page-organised nonvolatile memory with a byte-wide host port. Host writes go into a 128-byte page buffer. Each buffer lane has a flag that marks it as loaded. Every accepted write restarts a load-window timer. The window closes when no write arrives for the window length, or when a write names a different page. A programming timer then runs. When it expires, only the flagged lanes are copied into the backing array and the flags are cleared.

From the first accepted write until the commit, the block is busy. During that time a read returns a status byte instead of array data:
- bit 7 is the complement of bit 7 of the last byte accepted;
- bit 6 flips on every busy read;
- the other bits are zero.

A host polls either bit to find the end of the write cycle. The window and programming lengths are parameters in clock cycles, so a bench can use short values.

Top module: `pagewr_engine`

## Requirements
- R1: After reset, rdata is 8'h00, the block is idle, and every array byte reads 8'hFF.
- R2: addr[6:0] selects the byte within a page and addr[ADDR_W-1:7] selects the page. The first write of a cycle fixes the page for the whole load.
- R3: A same-page write that arrives within LOAD_WIN_CYC cycles of the previous accepted write is loaded. If no write arrives for LOAD_WIN_CYC cycles, loading stops and programming begins. A write that arrives after that is not loaded.
- R4: A write to a different page while loading closes the window. That write is discarded.
- R5: Bytes may be loaded in any order. When one offset is written several times in a load, the last value written is committed.
- R6: At commit only the loaded bytes of the page change. Every other byte of the array keeps its value.
- R7: While the block is busy (loading or programming), a read returns bit 7 equal to the inverse of bit 7 of the last accepted write byte, and bits 5:0 equal to zero.
- R8: Bit 6 of the status is 0 on the first busy read of a write cycle and inverts on each further busy read.
- R9: Programming lasts PROG_CYC cycles after the window closes. Reads then return true array data, and the next write starts a new cycle.
- R10: Writes during programming are ignored. The loaded flags are all clear after the commit.
- R11: rdata is registered. It changes only on the clock edge at which rd_en is sampled high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write request |
| rd_en | input | 1 | Byte read request |
| addr | input | ADDR_W | Byte address: page in the upper bits, offset in the lower 7 bits |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read result: array data when idle, status byte when busy |

## Verification
The bench sets write gaps just under and just over the window length. A design that gets the window length wrong by one would either lose the late byte or take in a byte that should be dropped. The bench also sends writes to a foreign page during a load, and writes during programming. A design that leaked either into the page would corrupt bytes the reference model keeps. It rewrites the same offset several times, so a design that keeps the first value shows up. It reads the whole array after random partial pages, so a commit that touches unflagged lanes or forgets to clear the flags shows up as a stale or overwritten byte. Back-to-back busy reads check that the toggle starts at zero and alternates, and that the polling bit inverts the last byte and not the first.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int BYTE_W   = 8;
    localparam int OFF_W    = 7;
    localparam int LANES    = 1 << OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pw_state_e;
endpackage

// File: rtl/cycle_timer.sv
module cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = en && !clr && (cnt_q == CNT_W'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (done) cnt_d = '0;
        else if (en)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/page_buffer.sv
module page_buffer
    import pw_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [OFF_W-1:0]             off,
    input  logic [BYTE_W-1:0]            din,
    input  logic                         clr,
    output logic [LANES-1:0][BYTE_W-1:0] data,
    output logic [LANES-1:0]             mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic              hit;
        logic [BYTE_W-1:0] byte_d, byte_q;
        logic              flag_d, flag_q;

        assign hit = wr && (off == OFF_W'(g));

        always_comb begin
            byte_d = hit ? din : byte_q;
            flag_d = clr ? 1'b0 : (flag_q | hit);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                flag_q <= 1'b0;
            end else begin
                byte_q <= byte_d;
                flag_q <= flag_d;
            end
        end

        assign data[g] = byte_q;
        assign mask[g] = flag_q;
    end
endmodule

// File: rtl/page_array.sv
module page_array
    import pw_pkg::*;
#(
    parameter int PAGE_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [PAGE_W-1:0]            cpage,
    input  logic [LANES-1:0][BYTE_W-1:0] cdata,
    input  logic [LANES-1:0]             cmask,
    input  logic [PAGE_W+OFF_W-1:0]      raddr,
    output logic [BYTE_W-1:0]            rbyte
);
    localparam int DEPTH = 1 << (PAGE_W + OFF_W);

    logic [BYTE_W-1:0] mem [DEPTH];

    assign rbyte = mem[raddr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int b = 0; b < LANES; b++)
                if (cmask[b]) mem[{cpage, OFF_W'(b)}] <= cdata[b];
        end
    end
endmodule

// File: rtl/pagewr_engine.sv
module pagewr_engine
    import pw_pkg::*;
#(
    parameter int PAGE_W       = 3,
    parameter int LOAD_WIN_CYC = 18750,
    parameter int PROG_CYC     = 1250000,
    localparam int ADDR_W      = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    typedef struct packed {
        pw_state_e         state;
        logic [PAGE_W-1:0] page;
        logic [BYTE_W-1:0] last;
        logic              tog;
        logic [BYTE_W-1:0] rdata;
    } eng_t;

    eng_t d, q;

    logic                         buf_wr, buf_clr, commit, ltmr_clr;
    logic                         load_done, prog_done;
    logic                         busy, st_load, st_prog;
    logic [LANES-1:0][BYTE_W-1:0] buf_data;
    logic [LANES-1:0]             buf_mask;
    logic [BYTE_W-1:0]            arr_byte;
    logic [PAGE_W-1:0]            addr_page, page_cur;

    assign addr_page = addr[ADDR_W-1:OFF_W];
    assign st_load   = (q.state == ST_LOAD);
    assign st_prog   = (q.state == ST_PROG);
    assign busy      = (q.state != ST_IDLE);
    assign page_cur  = q.page;
    assign rdata     = q.rdata;

    cycle_timer #(.LIMIT(LOAD_WIN_CYC)) u_ltmr (
        .clk(clk), .rst_n(rst_n), .clr(ltmr_clr), .en(st_load), .done(load_done)
    );

    cycle_timer #(.LIMIT(PROG_CYC)) u_ptmr (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .en(st_prog), .done(prog_done)
    );

    page_buffer u_buf (
        .clk(clk), .rst_n(rst_n), .wr(buf_wr), .off(addr[OFF_W-1:0]),
        .din(wdata), .clr(buf_clr), .data(buf_data), .mask(buf_mask)
    );

    page_array #(.PAGE_W(PAGE_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cpage(q.page),
        .cdata(buf_data), .cmask(buf_mask), .raddr(addr), .rbyte(arr_byte)
    );

    always_comb begin
        d        = q;
        buf_wr   = 1'b0;
        buf_clr  = 1'b0;
        commit   = 1'b0;
        ltmr_clr = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                if (wr_en) begin
                    buf_wr   = 1'b1;
                    ltmr_clr = 1'b1;
                    d.page   = addr_page;
                    d.last   = wdata;
                    d.tog    = 1'b0;
                    d.state  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (wr_en && (addr_page == q.page)) begin
                    buf_wr   = 1'b1;
                    ltmr_clr = 1'b1;
                    d.last   = wdata;
                end else if (wr_en || load_done) begin
                    d.state  = ST_PROG;
                end
            end
            ST_PROG: begin
                if (prog_done) begin
                    commit  = 1'b1;
                    buf_clr = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (rd_en) begin
            if (busy) begin
                d.rdata = {~q.last[BYTE_W-1], q.tog, {(BYTE_W-2){1'b0}}};
                d.tog   = ~q.tog;
            end else begin
                d.rdata = arr_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.page  <= '0;
            q.last  <= '0;
            q.tog   <= 1'b0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pw_checker.sv
module pw_checker
    import pw_pkg::*;
#(
    parameter int PAGE_W       = 3,
    parameter int LOAD_WIN_CYC = 16,
    localparam int CNT_W       = $clog2(LOAD_WIN_CYC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              busy,
    input logic              st_load,
    input logic              st_prog,
    input logic              commit,
    input logic [LANES-1:0]  mask,
    input logic [PAGE_W-1:0] page_cur,
    input logic [CNT_W-1:0]  ltmr_cnt,
    input logic [BYTE_W-1:0] rdata
);
    a_r7_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rd_en |=> rdata[5:0] == 6'd0);

    a_r8_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) ##1 (busy && rd_en) |=> rdata[6] != $past(rdata[6]));

    a_r10_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> mask == '0);

    a_r10_no_load_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        st_prog && $past(st_prog) |-> $stable(mask));

    a_r2_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        st_load && $past(st_load) |-> $stable(page_cur));

    a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ltmr_cnt < CNT_W'(LOAD_WIN_CYC));

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind pagewr_engine pw_checker #(.PAGE_W(PAGE_W), .LOAD_WIN_CYC(LOAD_WIN_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy), .st_load(st_load),
    .st_prog(st_prog), .commit(commit), .mask(buf_mask), .page_cur(page_cur),
    .ltmr_cnt(u_ltmr.cnt_q), .rdata(rdata)
);

// File: tb/sim_pagewr_engine.sv
`timescale 1ns/1ps
module sim_pagewr_engine;
    localparam int PW    = 3;
    localparam int LWIN  = 16;
    localparam int PCYC  = 48;
    localparam int AW    = PW + 7;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;

    int  n_chk = 0, n_bad = 0;
    bit  done_flag = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] pend  [128];
    bit         pflag [128];
    logic [7:0] last_b;
    bit         tog_m;
    int         cur_page;

    always #4 clk = ~clk;

    pagewr_engine #(.PAGE_W(PW), .LOAD_WIN_CYC(LWIN), .PROG_CYC(PCYC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] status_exp(logic [7:0] lb, bit t);
        return {~lb[7], t, 6'd0};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(int pg, int off, logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'((pg << 7) | off); wdata = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_read(int a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(a);
        @(posedge clk); #1;
        rd_en = 1'b0;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic start_cycle(int pg);
        cur_page = pg;
        tog_m = 0;
        for (int i = 0; i < 128; i++) pflag[i] = 0;
    endtask

    task automatic load(int off, logic [7:0] v);
        do_write(cur_page, off, v);
        pend[off] = v; pflag[off] = 1; last_b = v;
    endtask

    task automatic status_read(string tag);
        logic [7:0] v;
        do_read(0, v);
        check(tag, v, status_exp(last_b, tog_m));
        tog_m = ~tog_m;
    endtask

    task automatic finish_cycle();
        idle(LWIN + PCYC + 4);
        for (int i = 0; i < 128; i++)
            if (pflag[i]) model[(cur_page << 7) | i] = pend[i];
    endtask

    task automatic verify_page(string tag, int pg);
        logic [7:0] v;
        for (int i = 0; i < 128; i++) begin
            do_read((pg << 7) | i, v);
            check(tag, v, model[(pg << 7) | i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        idle(3);
        #1 check("R1 rdata after reset", rdata, 8'h00);
        rst_n = 1'b1;
        idle(2);
        do_read(5, v);           check("R1 erased byte", v, 8'hFF);
        do_read(DEPTH - 1, v);   check("R1 erased top byte", v, 8'hFF);

        // R5 rewrite and out-of-order load, R7/R8 status polling
        start_cycle(2);
        load(100, 8'h11); load(3, 8'h22); load(100, 8'hC5); load(3, 8'h7A);
        status_read("R7 R8 first busy read");
        status_read("R8 second busy read");
        status_read("R8 third busy read");
        finish_cycle();
        do_read((2 << 7) | 100, v); check("R5 last value kept", v, 8'hC5);
        do_read((2 << 7) | 3, v);   check("R5 last value kept low", v, 8'h7A);
        verify_page("R6 page 2 untouched lanes", 2);

        // R3 gap just under the window keeps loading
        start_cycle(1);
        load(10, 8'hA0);
        idle(LWIN - 3);
        load(11, 8'h0B);
        finish_cycle();
        do_read((1 << 7) | 11, v); check("R3 late byte inside window", v, 8'h0B);

        // R3 gap past the window: later write dropped (programming running)
        start_cycle(1);
        load(20, 8'h5C);
        idle(LWIN + 3);
        do_write(1, 21, 8'h99);
        status_read("R7 busy after window close");
        finish_cycle();
        do_read((1 << 7) | 21, v); check("R3 write after window dropped", v, 8'hFF);
        do_read((1 << 7) | 20, v); check("R9 committed byte readable", v, 8'h5C);

        // R4 page change closes the window; R10 write during programming ignored
        start_cycle(4);
        load(7, 8'h3D);
        do_write(5, 7, 8'hE1);
        idle(8);
        do_write(4, 8, 8'h42);
        status_read("R7 status ignores dropped writes");
        finish_cycle();
        do_read((5 << 7) | 7, v); check("R4 foreign page write discarded", v, 8'hFF);
        do_read((4 << 7) | 8, v); check("R10 write in programming ignored", v, 8'hFF);
        do_read((4 << 7) | 7, v); check("R2 byte landed at latched page", v, 8'h3D);

        // R6 full page load
        start_cycle(6);
        for (int i = 127; i >= 0; i--) load(i, 8'(i * 3 + 1));
        status_read("R7 after full page");
        finish_cycle();
        verify_page("R6 full page", 6);

        // R10 flags cleared: a one-byte cycle must not re-commit earlier lanes
        model[(6 << 7) | 0] = 8'h01;
        start_cycle(6);
        load(0, 8'h01);
        finish_cycle();
        verify_page("R10 flags cleared after commit", 6);

        // random cycles, R9 back-to-back
        for (int s = 0; s < 24; s++) begin
            int n;
            start_cycle(int'($urandom_range(0, (1 << PW) - 1)));
            n = int'($urandom_range(1, 20));
            for (int k = 0; k < n; k++) begin
                load(int'($urandom_range(0, 127)), 8'($urandom));
                idle(int'($urandom_range(0, LWIN - 4)));
            end
            if ($urandom_range(0, 1) == 1) status_read("R8 random busy read");
            if ($urandom_range(0, 2) == 0)
                do_write((cur_page + 1) % (1 << PW), 0, 8'h00);
            finish_cycle();
        end
        for (int p = 0; p < (1 << PW); p++) verify_page("R9 R6 array sweep", p);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule